// File: doc/BRIEF.md
# Comparator Output Conditioning and Status Unit

This block is the digital back end of an analog voltage comparator. The analog front end delivers a raw, asynchronous one-bit compare result. This block resynchronises that result and optionally inverts it. It can then pass the result through a sampling filter that rejects short glitches. It drives a gated output towards a pin path. Rising and falling transitions of the conditioned result are caught in sticky flags, which are cleared by writing one. Each flag can raise an interrupt request or a DMA request.

A small register bus programs the unit. Software sets the global enable, inversion, output source, pin gating, filter mode, sample period and the number of matching samples. It also sets the positive and negative input-select codes that go to the analog multiplexer, and a gated reference code for the resistor-ladder DAC. When the two input selects are equal, the comparator counts as disabled and its output is forced low, just as it is when the global enable is clear.

Top module: `cmpc_top`

## Requirements
- R1: The raw input passes through a two-flop synchronizer. When CTRL bit 1 (invert) is 1, `cmp_out` is the inverse of the raw level. When that bit is 0, `cmp_out` follows the raw level.
- R2: When CTRL bit 0 (enable) is 0, or when MUX bits 2:0 equal MUX bits 5:3, `cmp_out` and `cmp_pin` settle to 0.
- R3: A 0-to-1 transition of `cmp_out` sets STATUS bit 0. A 1-to-0 transition sets STATUS bit 1.
- R4: Writing 1 to STATUS bit 0 or bit 1 clears that flag. Writing 0 leaves it unchanged.
- R5: The interrupt-enable bits are STATUS bit 2 (rising flag) and bit 3 (falling flag). When STATUS bit 4 (DMA enable) is 0, any enabled flag raises `irq`. When bit 4 is 1, the enabled flags raise `dma_req` and `irq` stays 0.
- R6: When CTRL bit 2 is 1, `cmp_pin` carries the unfiltered result. When it is 0, `cmp_pin` carries the filtered result.
- R7: When CTRL bit 3 (pin enable) is 0, `cmp_pin` is 0.
- R8: With internal sampling and PERIOD = 0, the filter is bypassed. With PERIOD = P > 0, a sample is taken every P clocks. `cmp_out` changes only after CTRL bits 7:5 (N, 0 counts as 1) consecutive samples agree, so a pulse shorter than P clocks is rejected when N ≥ 2.
- R9: When CTRL bit 4 is 1, PERIOD is ignored and samples are taken only on `sample_strobe` pulses.
- R10: Enabling or disabling the block sets no edge flag.
- R11: The DAC register holds the code in bits 5:0 and an enable in bit 7. `dac_code` equals the code while the enable is 1, and is 0 otherwise.
- R12: The registers read back at these addresses: CTRL 0, PERIOD 1, STATUS 2, MUX 3, DAC 4. STATUS bit 7 reads the live `cmp_out`. `bus_rdata` is valid the cycle after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_raw | input | 1 | Asynchronous raw comparator result |
| sample_strobe | input | 1 | External sample strobe, one clock wide |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| pos_sel | output | 3 | Positive input-select code |
| neg_sel | output | 3 | Negative input-select code |
| dac_code | output | 6 | Gated DAC reference code |
| cmp_out | output | 1 | Conditioned (filtered) result |
| cmp_pin | output | 1 | Result gated toward the pin path |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
Some properties are checked on every cycle. A flag can rise only after an edge event. `irq` and `dma_req` are never high together. A disabled comparator holds its output low. A cleared pin enable keeps the pin low. The filtered level moves only on a sample point. No edge event appears right after activation. Other behaviour needs the bench's scenarios: the inversion table, glitch rejection against the period and count, ignoring the period in strobe mode, write-one-to-clear with write-zero masking, and the DAC gating.

// File: rtl/cmpc_pkg.sv
package cmpc_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_PERIOD = 3'd1;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd2;
  localparam logic [ADDR_W-1:0] A_MUX    = 3'd3;
  localparam logic [ADDR_W-1:0] A_DAC    = 3'd4;

  // control register layout, msb first
  typedef struct packed {
    logic [2:0] need;      // consecutive matching samples
    logic       ext;       // external strobe sampling
    logic       pin_en;    // gate result onto pin
    logic       pass_raw;  // pin takes unfiltered result
    logic       inv;       // invert raw result
    logic       en;        // global enable
  } ctrl_t;
endpackage

// File: rtl/cmpc_sync.sv
module cmpc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cmpc_filter.sv
module cmpc_filter #(
  parameter int PER_W = 8,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             din,
  input  logic             ext,
  input  logic             strobe,
  input  logic [PER_W-1:0] period,
  input  logic [CNT_W-1:0] need,
  output logic             dout
);
  localparam logic [CNT_W-1:0] RUN_MAX = {CNT_W{1'b1}};

  logic [PER_W-1:0] div_q;
  logic [CNT_W-1:0] run_q, run_nx, need_eff;
  logic             last_q, filt_q;
  logic             bypass, tick_int, tick, match;

  assign bypass   = !ext && (period == '0);
  assign tick_int = !ext && !bypass &&
                    (({1'b0, div_q} + 1'b1) >= {1'b0, period});
  assign tick     = ext ? strobe : tick_int;
  assign need_eff = (need == '0) ? CNT_W'(1) : need;
  assign match    = (din == last_q) && (run_q != '0);

  always_comb begin
    if (!match)              run_nx = CNT_W'(1);
    else if (run_q == RUN_MAX) run_nx = run_q;
    else                     run_nx = run_q + 1'b1;
  end

  // sample-point divider
  always_ff @(posedge clk) begin
    if (rst || !active || ext || bypass) div_q <= '0;
    else if (tick_int)                   div_q <= '0;
    else                                 div_q <= div_q + 1'b1;
  end

  // run-length qualifier
  always_ff @(posedge clk) begin
    if (rst || !active) begin
      run_q  <= '0;
      last_q <= 1'b0;
      filt_q <= 1'b0;
    end else if (bypass) begin
      run_q  <= '0;
      last_q <= din;
      filt_q <= din;
    end else if (tick) begin
      run_q  <= run_nx;
      last_q <= din;
      if (run_nx >= need_eff) filt_q <= din;
    end
  end

  assign dout = bypass ? din : filt_q;

  // R8
  filt_on_sample_chk: assert property (@(posedge clk) disable iff (rst)
    (filt_q != $past(filt_q)) |-> $past(tick || bypass || !active || rst));
endmodule

// File: rtl/cmpc_edge.sv
module cmpc_edge (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic lvl,
  output logic rise_evt,
  output logic fall_evt
);
  logic armed_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q  <= 1'b0;
      prev_q   <= 1'b0;
      rise_evt <= 1'b0;
      fall_evt <= 1'b0;
    end else begin
      armed_q  <= active;
      prev_q   <= lvl;
      rise_evt <= active && armed_q && lvl && !prev_q;
      fall_evt <= active && armed_q && !lvl && prev_q;
    end
  end

  // R10
  no_enable_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |=> (!rise_evt && !fall_evt));
endmodule

// File: rtl/cmpc_regs.sv
module cmpc_regs
  import cmpc_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter int DAC_W = 6,
  parameter int PER_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              live,
  output ctrl_t             ctrl,
  output logic [PER_W-1:0]  period,
  output logic [SEL_W-1:0]  pos_sel,
  output logic [SEL_W-1:0]  neg_sel,
  output logic [DAC_W-1:0]  dac_code,
  output logic              irq,
  output logic              dma_req,
  output logic [DATA_W-1:0] rdata
);
  logic             rflag, fflag, rie, fie, dma_en, dac_en;
  logic [DAC_W-1:0] dac_val;
  logic             w_ctrl, w_per, w_stat, w_mux, w_dac, req;
  logic             unused_bits;

  assign w_ctrl = wr_en && (addr == A_CTRL);
  assign w_per  = wr_en && (addr == A_PERIOD);
  assign w_stat = wr_en && (addr == A_STATUS);
  assign w_mux  = wr_en && (addr == A_MUX);
  assign w_dac  = wr_en && (addr == A_DAC);
  assign unused_bits = ^{wdata[6:5], wdata[7:6], wdata[6]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= '0;
      period  <= '0;
      rie     <= 1'b0;
      fie     <= 1'b0;
      dma_en  <= 1'b0;
      pos_sel <= '0;
      neg_sel <= '0;
      dac_en  <= 1'b0;
      dac_val <= '0;
    end else begin
      if (w_ctrl) ctrl <= ctrl_t'(wdata);
      if (w_per)  period <= wdata[PER_W-1:0];
      if (w_stat) begin
        rie    <= wdata[2];
        fie    <= wdata[3];
        dma_en <= wdata[4];
      end
      if (w_mux) begin
        pos_sel <= wdata[SEL_W-1:0];
        neg_sel <= wdata[2*SEL_W-1:SEL_W];
      end
      if (w_dac) begin
        dac_val <= wdata[DAC_W-1:0];
        dac_en  <= wdata[7];
      end
    end
  end

  // sticky edge flags, a new event wins over a clear
  always_ff @(posedge clk) begin
    if (rst) begin
      rflag <= 1'b0;
      fflag <= 1'b0;
    end else begin
      rflag <= rise_evt || (rflag && !(w_stat && wdata[0]));
      fflag <= fall_evt || (fflag && !(w_stat && wdata[1]));
    end
  end

  assign req = (rflag && rie) || (fflag && fie);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq     <= 1'b0;
      dma_req <= 1'b0;
    end else begin
      irq     <= req && !dma_en;
      dma_req <= req && dma_en;
    end
  end

  assign dac_code = dac_en ? dac_val : '0;

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        A_CTRL:   rdata <= ctrl;
        A_PERIOD: rdata <= DATA_W'(period);
        A_STATUS: rdata <= {live, 2'b00, dma_en, fie, rie, fflag, rflag};
        A_MUX:    rdata <= DATA_W'({neg_sel, pos_sel});
        A_DAC:    rdata <= {dac_en, 1'b0, dac_val};
        default:  rdata <= '0;
      endcase
    end
  end

  // R4
  rflag_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rflag) |-> $past(rise_evt));
  // R4
  fflag_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fflag) |-> $past(fall_evt));
  // R5
  req_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(irq && dma_req));
  // R5
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past((rflag && rie) || (fflag && fie)));
endmodule

// File: rtl/cmpc_top.sv
module cmpc_top
  import cmpc_pkg::*;
#(
  parameter int SEL_W     = 3,
  parameter int DAC_W     = 6,
  parameter int PER_W     = 8,
  parameter int CNT_W     = 3,
  parameter int SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmp_raw,
  input  logic              sample_strobe,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [SEL_W-1:0]  pos_sel,
  output logic [SEL_W-1:0]  neg_sel,
  output logic [DAC_W-1:0]  dac_code,
  output logic              cmp_out,
  output logic              cmp_pin,
  output logic              irq,
  output logic              dma_req
);
  ctrl_t            ctrl;
  logic [PER_W-1:0] period;
  logic             raw_s, active, active_d, unf_q, filt_lvl;
  logic             rise_evt, fall_evt;

  cmpc_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .d(cmp_raw), .q(raw_s)
  );

  assign active = ctrl.en && (pos_sel != neg_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_d <= 1'b0;
      unf_q    <= 1'b0;
      cmp_pin  <= 1'b0;
    end else begin
      active_d <= active;
      unf_q    <= active && (raw_s ^ ctrl.inv);
      cmp_pin  <= ctrl.pin_en && (ctrl.pass_raw ? unf_q : filt_lvl);
    end
  end

  cmpc_filter #(.PER_W(PER_W), .CNT_W(CNT_W)) u_filter (
    .clk(clk), .rst(rst), .active(active_d), .din(unf_q),
    .ext(ctrl.ext), .strobe(sample_strobe), .period(period),
    .need(ctrl.need), .dout(filt_lvl)
  );

  cmpc_edge u_edge (
    .clk(clk), .rst(rst), .active(active_d), .lvl(filt_lvl),
    .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  cmpc_regs #(.SEL_W(SEL_W), .DAC_W(DAC_W), .PER_W(PER_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .rise_evt(rise_evt), .fall_evt(fall_evt),
    .live(filt_lvl), .ctrl(ctrl), .period(period), .pos_sel(pos_sel),
    .neg_sel(neg_sel), .dac_code(dac_code), .irq(irq), .dma_req(dma_req),
    .rdata(bus_rdata)
  );

  assign cmp_out = filt_lvl;

  // R2
  disabled_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!active_d && !$past(active_d)) |-> !cmp_out);
  // R7
  pin_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl.pin_en |=> !cmp_pin);
endmodule

// File: tb/cmpc_top_tb.sv
module cmpc_top_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmp_raw = 1'b0, sample_strobe = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [2:0] pos_sel, neg_sel;
  logic [5:0] dac_code;
  logic       cmp_out, cmp_pin, irq, dma_req;
  int         n_chk = 0, n_fail = 0;
  logic       done = 1'b0;
  logic [7:0] rd;

  always #5 clk = ~clk;

  cmpc_top u_dut (
    .clk(clk), .rst(rst), .cmp_raw(cmp_raw), .sample_strobe(sample_strobe),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pos_sel(pos_sel),
    .neg_sel(neg_sel), .dac_code(dac_code), .cmp_out(cmp_out),
    .cmp_pin(cmp_pin), .irq(irq), .dma_req(dma_req)
  );

  // {invert, raw, expected cmp_out}
  localparam logic [2:0] VEC [8] = '{
    3'b000, 3'b011, 3'b110, 3'b101, 3'b011, 3'b000, 3'b101, 3'b000
  };

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rdreg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe();
    @(negedge clk); sample_strobe = 1'b1;
    @(negedge clk); sample_strobe = 1'b0;
    cyc(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(3);
    @(negedge clk) rst = 1'b0;
    cyc(2);
    // R12 reset state
    check("R12 reset outputs", {cmp_out, cmp_pin, irq, dma_req}, 0);
    rdreg(3'd0, rd); check("R12 ctrl reset", rd, 8'h00);

    wr(3'd3, 8'h01);                 // pos 1, neg 0
    rdreg(3'd3, rd); check("R12 mux readback", rd, 8'h01);
    // R1 table walk, filter bypassed, pin enabled
    foreach (VEC[i]) begin
      wr(3'd0, 8'h09 | {6'b0, VEC[i][2], 1'b0});
      cmp_raw = VEC[i][1];
      cyc(8);
      check("R1 inversion", cmp_out, VEC[i][0]);
      check("R7 pin follows", cmp_pin, VEC[i][0]);
    end

    // R3 edge flags
    wr(3'd0, 8'h09); cmp_raw = 1'b0; cyc(8);
    wr(3'd2, 8'h03);
    rdreg(3'd2, rd); check("R4 cleared", rd[1:0], 0);
    cmp_raw = 1'b1; cyc(10);
    rdreg(3'd2, rd); check("R3 rise flag", rd[1:0], 2'b01);
    check("R12 live bit", rd[7], 1);
    cmp_raw = 1'b0; cyc(10);
    rdreg(3'd2, rd); check("R3 fall flag", rd[1:0], 2'b11);
    // R4 write-one-to-clear
    wr(3'd2, 8'h00); rdreg(3'd2, rd); check("R4 zero write keeps", rd[1:0], 2'b11);
    wr(3'd2, 8'h01); rdreg(3'd2, rd); check("R4 clear rise only", rd[1:0], 2'b10);
    wr(3'd2, 8'h02); rdreg(3'd2, rd); check("R4 clear fall", rd[1:0], 2'b00);

    // R5 interrupt and DMA routing
    wr(3'd2, 8'h04); cyc(3);
    check("R5 irq idle", irq, 0);
    cmp_raw = 1'b1; cyc(10);
    check("R5 irq on rise", irq, 1);
    check("R5 no dma", dma_req, 0);
    wr(3'd2, 8'h05); cyc(3);
    check("R5 irq cleared", irq, 0);
    wr(3'd2, 8'h14);
    cmp_raw = 1'b0; cyc(10);
    check("R5 fall not enabled", {irq, dma_req}, 0);
    cmp_raw = 1'b1; cyc(10);
    check("R5 dma on rise", {irq, dma_req}, 2'b01);
    wr(3'd2, 8'h03); cyc(3);
    check("R5 dma cleared", dma_req, 0);

    // R7 pin gating
    wr(3'd0, 8'h01); cyc(6);
    check("R7 pin off", cmp_pin, 0);
    check("R7 out still high", cmp_out, 1);

    // R8 filter: period 4, three samples
    wr(3'd1, 8'h04); wr(3'd0, 8'h69);
    cmp_raw = 1'b0; cyc(30);
    check("R8 settled low", cmp_out, 0);
    @(negedge clk) cmp_raw = 1'b1;
    cyc(2); cmp_raw = 1'b0;
    cyc(30);
    check("R8 glitch rejected", cmp_out, 0);
    cmp_raw = 1'b1; cyc(6);
    check("R8 not yet qualified", cmp_out, 0);
    cyc(24);
    check("R8 qualified", cmp_out, 1);
    // R6 pin takes unfiltered value
    wr(3'd0, 8'h6D);
    cmp_raw = 1'b0; cyc(6);
    check("R6 pin unfiltered", cmp_pin, 0);
    check("R6 filtered lags", cmp_out, 1);
    cyc(30);
    check("R8 filtered low", cmp_out, 0);

    // R9 external strobe mode, two samples, period ignored
    wr(3'd0, 8'h59);
    cmp_raw = 1'b1; cyc(40);
    check("R9 period ignored", cmp_out, 0);
    strobe(); strobe();
    check("R9 strobe sampling", cmp_out, 1);

    // R2 and R10 enable gating
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h08); cyc(10);
    check("R2 disabled low", {cmp_out, cmp_pin}, 0);
    wr(3'd2, 8'h03);
    wr(3'd0, 8'h09); cyc(10);
    check("R10 output after enable", cmp_out, 1);
    rdreg(3'd2, rd); check("R10 no flag on enable", rd[1:0], 0);
    wr(3'd3, 8'h09); cyc(10);
    check("R2 equal selects", {cmp_out, cmp_pin}, 0);
    rdreg(3'd2, rd); check("R10 no flag on disable", rd[1:0], 0);
    check("R2 selects out", {pos_sel, neg_sel}, 6'o11);

    // R11 DAC gating
    wr(3'd4, 8'h25); cyc(1);
    check("R11 dac gated off", dac_code, 0);
    wr(3'd4, 8'hA5); cyc(1);
    check("R11 dac on", dac_code, 6'h25);
    rdreg(3'd4, rd); check("R12 dac readback", rd, 8'hA5);
    rdreg(3'd1, rd); check("R12 period readback", rd, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule